// File: doc/BRIEF.md
# Bus Access Break Condition Comparator

This block is a two-channel hardware breakpoint comparator that sits beside a processor bus. On every access it looks at the bus (internal or local), the cycle kind (instruction fetch or data access), the direction, the operand size, a 32-bit address, an 8-bit address-space ID (ASID) and a 32-bit data value. Each channel has its own programmed conditions. When every enabled condition of a channel agrees with a valid access, that channel raises a one-cycle break pulse and sets a sticky match flag. The two channels work independently.

Both channels compare the address, the address mask, the ASID and a cycle condition word. Only channel B also compares data, through a value and a per-bit mask. The address compare follows the access size. An aligned access of any width hits when the bytes it spans include the target address. When the size field of the condition is set, only accesses of that size can hit. For data, the byte or halfword lane named by the low address bits is moved down to the bottom of the word before the masked compare. Software sets up the channels through a small register port, reads them back and clears the flags.

Top module: `bus_brk_cmp`

## Requirements
- R1: After reset both break pulses are 0, the flag register reads 0 and every channel register reads 0. A channel whose condition has enable bit 9 clear never breaks.
- R2: An address-mask bit at 1 makes that address bit a don't-care. With mask 0x000000FF, any hitting address that shares bits 31:8 with the target matches.
- R3: The access width is 1, 2 or 4 bytes for size codes 0, 1 and 2, and code 3 counts as 4. An aligned access hits on address when the bytes it spans include the target, so with target ...56 a longword at ...54, a word at ...56 and a byte at ...56 hit, while a byte at ...57 or a word at ...54 does not.
- R4: An access whose address is not a multiple of its width never breaks. Size field bits 7:6 of the condition work as follows: 0 means any size, and codes 1, 2 and 3 require access size 0, 1 and 2 respectively.
- R5: A break requires the ASID of the access to equal the channel's programmed ASID.
- R6: The condition word holds three 2-bit fields: bus at bits 1:0 (1 = internal, access bus=0; 2 = local, access bus=1), kind at bits 3:2 (1 = fetch, kind=0; 2 = data, kind=1) and direction at bits 5:4 (1 = read, wr=0; 2 = write, wr=1). For each field, 0 is don't care and 3 never matches.
- R7: On channel B with data-enable bit 8 set, the compare takes the access data lane: a byte from bits 8*addr[1:0]+7..8*addr[1:0], a word from bits 16*addr[1]+15..16*addr[1], or the whole longword. It compares that lane with the low 8, 16 or 32 bits of the value register, and bits where the data mask is 1 are excluded.
- R8: Channel A never compares data: its break does not depend on the access data.
- R9: A break pulse is high exactly in the cycle after the clock edge that sampled a hitting access with acc_valid_i high. It lasts one cycle, and nothing is produced while acc_valid_i is low.
- R10: A break sets flag bit 0 (A) or bit 1 (B) of register 10. Each flag stays set until a write to register 10 with a 1 in that bit.
- R11: The register map is: 0/4 target address, 1/5 address mask, 2/6 ASID (8 bits), 3/7 condition (10 bits) for A/B, 8 channel B data value, 9 channel B data mask. Written values read back on reg_rdata_o, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register index for write and read |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| acc_valid_i | input | 1 | Bus access present this cycle |
| acc_bus_i | input | 1 | 0 internal bus, 1 local bus |
| acc_kind_i | input | 1 | 0 instruction fetch, 1 data access |
| acc_wr_i | input | 1 | 0 read, 1 write |
| acc_size_i | input | 2 | 0 byte, 1 word, 2 longword |
| acc_addr_i | input | 32 | Access byte address |
| acc_asid_i | input | 8 | Access address-space ID |
| acc_data_i | input | 32 | Access data on the full bus width |
| brk_a_o | output | 1 | Channel A break pulse |
| brk_b_o | output | 1 | Channel B break pulse |

## Verification
The hardest case to reach from the ports is a channel B data hit. It needs the masked address, the ASID, all cycle fields and the steered data lane to agree at once, and pure random data almost never lines up with the lane picked by the address. The stimulus therefore places the programmed value in the lane the address selects on about half of the accesses. It draws addresses by flipping only a few low bits of the target and mostly uses the ASID that was programmed. Directed accesses cover the covering-width cases, misaligned words at the edge of a masked block, and a byte placed in the wrong lane.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [1:0] {
    FLD_ANY   = 2'b00,
    FLD_LO    = 2'b01,
    FLD_HI    = 2'b10,
    FLD_NEVER = 2'b11
  } fld_e;

  typedef struct packed {
    logic       en;
    logic       data_en;
    logic [1:0] size;
    fld_e       dir;
    fld_e       kind;
    fld_e       bus;
  } brk_cond_t;

  localparam int CondW   = $bits(brk_cond_t);
  localparam int NumCh   = 2;
  localparam int RegAW   = 4;
  localparam logic [RegAW-1:0] RegDval  = 4'd8;
  localparam logic [RegAW-1:0] RegDmask = 4'd9;
  localparam logic [RegAW-1:0] RegFlag  = 4'd10;
endpackage

// File: rtl/brk_cycle_match.sv
module brk_cycle_match
  import brk_pkg::*;
(
  input  brk_cond_t  cond_i,
  input  logic       bus_i,
  input  logic       kind_i,
  input  logic       wr_i,
  input  logic [1:0] size_i,
  output logic       hit_o
);
  function automatic logic fld_ok(fld_e f, logic v);
    unique case (f)
      FLD_ANY: fld_ok = 1'b1;
      FLD_LO:  fld_ok = ~v;
      FLD_HI:  fld_ok = v;
      default: fld_ok = 1'b0;
    endcase
  endfunction

  logic size_ok;
  assign size_ok = (cond_i.size == 2'd0) || (size_i == cond_i.size - 2'd1);
  assign hit_o   = fld_ok(cond_i.bus, bus_i) & fld_ok(cond_i.kind, kind_i) &
                   fld_ok(cond_i.dir, wr_i) & size_ok;
endmodule

// File: rtl/brk_addr_match.sv
module brk_addr_match #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] tgt_i,
  input  logic [AW-1:0] mask_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  output logic          hit_o
);
  logic [1:0]    low_ign;
  logic [AW-1:0] ign;
  logic          aligned;

  always_comb begin
    unique case (size_i)
      2'd0:    low_ign = 2'b00;
      2'd1:    low_ign = 2'b01;
      default: low_ign = 2'b11;
    endcase
  end

  assign ign     = {{(AW-2){1'b0}}, low_ign};
  assign aligned = (addr_i & ign) == '0;
  // bytes spanned by the access differ only in the ignored low bits
  assign hit_o   = aligned && (((addr_i ^ tgt_i) & ~mask_i & ~ign) == '0);
endmodule

// File: rtl/brk_data_match.sv
module brk_data_match #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] dval_i,
  input  logic [DW-1:0] dmask_i,
  input  logic [DW-1:0] data_i,
  input  logic [1:0]    addr_lo_i,
  input  logic [1:0]    size_i,
  output logic          hit_o
);
  localparam logic [DW-1:0] ByteM = {{(DW-8){1'b0}}, 8'hFF};
  localparam logic [DW-1:0] WordM = {{(DW-16){1'b0}}, 16'hFFFF};

  logic [DW-1:0] lane, wmask;

  always_comb begin
    unique case (size_i)
      2'd0: begin
        lane  = data_i >> (8 * int'(addr_lo_i));
        wmask = ByteM;
      end
      2'd1: begin
        lane  = data_i >> (16 * int'(addr_lo_i[1]));
        wmask = WordM;
      end
      default: begin
        lane  = data_i;
        wmask = '1;
      end
    endcase
  end

  assign hit_o = ((lane ^ dval_i) & ~dmask_i & wmask) == '0;
endmodule

// File: rtl/brk_channel.sv
module brk_channel
  import brk_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int ASIDW    = 8,
  parameter bit HAS_DATA = 1'b0
) (
  input  brk_cond_t        cond_i,
  input  logic [AW-1:0]    tgt_i,
  input  logic [AW-1:0]    mask_i,
  input  logic [ASIDW-1:0] asid_i,
  input  logic [DW-1:0]    dval_i,
  input  logic [DW-1:0]    dmask_i,
  input  logic             acc_bus_i,
  input  logic             acc_kind_i,
  input  logic             acc_wr_i,
  input  logic [1:0]       acc_size_i,
  input  logic [AW-1:0]    acc_addr_i,
  input  logic [ASIDW-1:0] acc_asid_i,
  input  logic [DW-1:0]    acc_data_i,
  output logic             hit_o
);
  logic cyc_hit, addr_hit, data_hit;

  brk_cycle_match u_cyc (
    .cond_i (cond_i),
    .bus_i  (acc_bus_i),
    .kind_i (acc_kind_i),
    .wr_i   (acc_wr_i),
    .size_i (acc_size_i),
    .hit_o  (cyc_hit)
  );

  brk_addr_match #(.AW(AW)) u_addr (
    .tgt_i  (tgt_i),
    .mask_i (mask_i),
    .addr_i (acc_addr_i),
    .size_i (acc_size_i),
    .hit_o  (addr_hit)
  );

  if (HAS_DATA) begin : g_data
    logic dcmp;
    brk_data_match #(.DW(DW)) u_data (
      .dval_i    (dval_i),
      .dmask_i   (dmask_i),
      .data_i    (acc_data_i),
      .addr_lo_i (acc_addr_i[1:0]),
      .size_i    (acc_size_i),
      .hit_o     (dcmp)
    );
    assign data_hit = ~cond_i.data_en | dcmp;
  end else begin : g_nodata
    logic unused_data;
    assign unused_data = ^{dval_i, dmask_i, acc_data_i, cond_i.data_en};
    assign data_hit    = 1'b1;
  end

  assign hit_o = cond_i.en && (acc_asid_i == asid_i) && cyc_hit && addr_hit && data_hit;
endmodule

// File: rtl/bus_brk_cmp.sv
module bus_brk_cmp
  import brk_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int ASIDW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [3:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  input  logic             acc_valid_i,
  input  logic             acc_bus_i,
  input  logic             acc_kind_i,
  input  logic             acc_wr_i,
  input  logic [1:0]       acc_size_i,
  input  logic [AW-1:0]    acc_addr_i,
  input  logic [ASIDW-1:0] acc_asid_i,
  input  logic [DW-1:0]    acc_data_i,
  output logic             brk_a_o,
  output logic             brk_b_o
);
  logic [AW-1:0]    tgt_q  [NumCh];
  logic [AW-1:0]    mask_q [NumCh];
  logic [ASIDW-1:0] asid_q [NumCh];
  brk_cond_t        cond_q [NumCh];
  logic [DW-1:0]    dval_q, dmask_q;
  logic [NumCh-1:0] flag_q, brk_q, hit;
  logic             flag_clr_wr;

  assign flag_clr_wr = reg_we_i && (reg_addr_i == RegFlag);

  for (genvar c = 0; c < NumCh; c++) begin : g_ch
    brk_channel #(
      .AW(AW), .DW(DW), .ASIDW(ASIDW), .HAS_DATA(c == 1)
    ) u_ch (
      .cond_i     (cond_q[c]),
      .tgt_i      (tgt_q[c]),
      .mask_i     (mask_q[c]),
      .asid_i     (asid_q[c]),
      .dval_i     (dval_q),
      .dmask_i    (dmask_q),
      .acc_bus_i  (acc_bus_i),
      .acc_kind_i (acc_kind_i),
      .acc_wr_i   (acc_wr_i),
      .acc_size_i (acc_size_i),
      .acc_addr_i (acc_addr_i),
      .acc_asid_i (acc_asid_i),
      .acc_data_i (acc_data_i),
      .hit_o      (hit[c])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tgt_q[c]  <= '0;
        mask_q[c] <= '0;
        asid_q[c] <= '0;
        cond_q[c] <= '0;
      end else if (reg_we_i && (reg_addr_i[3:2] == 2'(c))) begin
        unique case (reg_addr_i[1:0])
          2'd0: tgt_q[c]  <= reg_wdata_i[AW-1:0];
          2'd1: mask_q[c] <= reg_wdata_i[AW-1:0];
          2'd2: asid_q[c] <= reg_wdata_i[ASIDW-1:0];
          default: cond_q[c] <= brk_cond_t'(reg_wdata_i[CondW-1:0]);
        endcase
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        brk_q[c]  <= 1'b0;
        flag_q[c] <= 1'b0;
      end else begin
        brk_q[c] <= acc_valid_i & hit[c];
        if (acc_valid_i && hit[c])                 flag_q[c] <= 1'b1;
        else if (flag_clr_wr && reg_wdata_i[c])    flag_q[c] <= 1'b0;
      end
    end

    p_pulse_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      brk_q[c] |-> $past(acc_valid_i));
    p_flag_follows_brk_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      brk_q[c] |-> flag_q[c]);
    p_flag_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_q[c] && !(flag_clr_wr && reg_wdata_i[c]) |=> flag_q[c]);
    p_asid_eq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      brk_q[c] |-> ($past(acc_asid_i) == $past(asid_q[c])));
    p_aligned_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      brk_q[c] |-> ($past(acc_size_i) == 2'd0 || $past(acc_addr_i[0]) == 1'b0));
    p_enabled_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      brk_q[c] |-> $past(cond_q[c].en));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dval_q  <= '0;
      dmask_q <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == RegDval)  dval_q  <= reg_wdata_i[DW-1:0];
      if (reg_addr_i == RegDmask) dmask_q <= reg_wdata_i[DW-1:0];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      4'd0: reg_rdata_o = 32'(tgt_q[0]);
      4'd1: reg_rdata_o = 32'(mask_q[0]);
      4'd2: reg_rdata_o = 32'(asid_q[0]);
      4'd3: reg_rdata_o = 32'(cond_q[0]);
      4'd4: reg_rdata_o = 32'(tgt_q[1]);
      4'd5: reg_rdata_o = 32'(mask_q[1]);
      4'd6: reg_rdata_o = 32'(asid_q[1]);
      4'd7: reg_rdata_o = 32'(cond_q[1]);
      4'd8: reg_rdata_o = 32'(dval_q);
      4'd9: reg_rdata_o = 32'(dmask_q);
      4'd10: reg_rdata_o = 32'(flag_q);
      default: reg_rdata_o = '0;
    endcase
  end

  assign brk_a_o = brk_q[0];
  assign brk_b_o = brk_q[1];

  p_single_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_a_o && !$past(acc_valid_i, 1) |-> 1'b0);
endmodule

// File: tb/bus_brk_cmp_tb.sv
module bus_brk_cmp_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        we = 0;
  logic [3:0]  raddr = 4'd10;
  logic [31:0] wdata = 0, rdata;
  logic        vld = 0, bus = 0, kind = 0, wr = 0;
  logic [1:0]  sz = 0;
  logic [31:0] addr = 0, data = 0;
  logic [7:0]  asid = 0;
  logic        brk_a, brk_b;

  int chk = 0, bad = 0;
  bit done = 0;

  logic [31:0] m_t[2], m_m[2], m_c[2];
  logic [7:0]  m_s[2];
  logic [31:0] m_dv, m_dm;
  logic [1:0]  m_flag;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_brk_cmp u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(raddr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .acc_valid_i(vld),
    .acc_bus_i(bus), .acc_kind_i(kind), .acc_wr_i(wr), .acc_size_i(sz),
    .acc_addr_i(addr), .acc_asid_i(asid), .acc_data_i(data),
    .brk_a_o(brk_a), .brk_b_o(brk_b)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cw(bit en, bit den, logic [1:0] s, logic [1:0] d,
                                     logic [1:0] k, logic [1:0] b);
    return {22'd0, en, den, s, d, k, b};
  endfunction

  function automatic bit fm(logic [1:0] f, logic v);
    return (f == 2'd0) || (f == 2'd1 && !v) || (f == 2'd2 && v);
  endfunction

  function automatic bit model(int ch);
    int w;
    bit cov;
    logic [31:0] v, mw;
    logic [31:0] c;
    c = m_c[ch];
    if (!c[9]) return 0;
    if (asid != m_s[ch]) return 0;
    if (!fm(c[1:0], bus) || !fm(c[3:2], kind) || !fm(c[5:4], wr)) return 0;
    if (c[7:6] != 0 && int'(sz) != int'(c[7:6]) - 1) return 0;
    w = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    if ((addr % w) != 0) return 0;
    cov = 0;
    for (int k = 0; k < w; k++)
      if ((((addr + k) ^ m_t[ch]) & ~m_m[ch]) == 0) cov = 1;
    if (!cov) return 0;
    if (ch == 1 && c[8]) begin
      if (w == 1)      begin v = (data >> (8 * addr[1:0])) & 32'hFF;   mw = 32'hFF;   end
      else if (w == 2) begin v = (data >> (16 * addr[1])) & 32'hFFFF; mw = 32'hFFFF; end
      else             begin v = data; mw = 32'hFFFF_FFFF; end
      if (((v ^ m_dv) & ~m_dm & mw) != 0) return 0;
    end
    return 1;
  endfunction

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1; raddr = a; wdata = d;
    case (a)
      4'd0: m_t[0] = d;  4'd1: m_m[0] = d;  4'd2: m_s[0] = d[7:0]; 4'd3: m_c[0] = d & 32'h3FF;
      4'd4: m_t[1] = d;  4'd5: m_m[1] = d;  4'd6: m_s[1] = d[7:0]; 4'd7: m_c[1] = d & 32'h3FF;
      4'd8: m_dv = d;    4'd9: m_dm = d;    4'd10: m_flag = m_flag & ~d[1:0];
      default: ;
    endcase
    @(negedge clk);
    we = 0; raddr = 4'd10;
  endtask

  task automatic acc(input string tag, input logic b, k, w, input logic [1:0] s,
                     input logic [31:0] a, input logic [7:0] id, input logic [31:0] d);
    bit ea, eb;
    @(negedge clk);
    vld = 1; bus = b; kind = k; wr = w; sz = s; addr = a; asid = id; data = d;
    ea = model(0); eb = model(1);
    @(negedge clk);
    vld = 0;
    check({tag, " brk_a"}, 32'(brk_a), 32'(ea));
    check({tag, " brk_b"}, 32'(brk_b), 32'(eb));
    m_flag = m_flag | {eb, ea};
    check({tag, " R10 flags"}, rdata, 32'(m_flag));
    @(negedge clk);
    check({tag, " R9 one-cycle"}, 32'({brk_a, brk_b}), 32'd0);
  endtask

  function automatic logic [1:0] rf();
    return ($urandom % 3 == 0) ? 2'($urandom % 4) : 2'd0;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++; chk++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", chk, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1ee7));
    for (int i = 0; i < 2; i++) begin m_t[i] = 0; m_m[i] = 0; m_c[i] = 0; m_s[i] = 0; end
    m_dv = 0; m_dm = 0; m_flag = 0;
    #(CLK_PERIOD * 3);
    @(negedge clk); rst_n = 1;

    // R1 reset state
    check("R1 brk after reset", 32'({brk_a, brk_b}), 32'd0);
    for (int r = 0; r < 11; r++) begin
      raddr = 4'(r); #1;
      check("R1 reg reset", rdata, 32'd0);
    end
    raddr = 4'd10;
    acc("R1 disabled", 0, 0, 0, 0, 32'h0, 8'h0, 32'h0);

    // local-bus data scenario
    wreg(0, 32'h0012_3456); wreg(1, 0); wreg(2, 32'h80);
    wreg(3, cw(1, 0, 2'd0, 2'd1, 2'd2, 2'd2));
    wreg(4, 32'h000A_BCDE); wreg(5, 32'hFF); wreg(6, 32'h70);
    wreg(7, cw(1, 1, 2'd2, 2'd2, 2'd2, 2'd2));
    wreg(8, 32'h0000_A512); wreg(9, 0);
    raddr = 4'd4; #1; check("R11 readback tgt B", rdata, 32'h000A_BCDE);
    raddr = 4'd7; #1; check("R11 readback cond B", rdata, 32'h3AA);
    raddr = 4'd10;

    acc("R3 long covers", 1, 1, 0, 2, 32'h0012_3454, 8'h80, 32'h0);
    acc("R3 word at tgt", 1, 1, 0, 1, 32'h0012_3456, 8'h80, 32'h0);
    acc("R3 byte at tgt", 1, 1, 0, 0, 32'h0012_3456, 8'h80, 32'h0);
    acc("R3 byte next", 1, 1, 0, 0, 32'h0012_3457, 8'h80, 32'h0);
    acc("R3 word below", 1, 1, 0, 1, 32'h0012_3454, 8'h80, 32'h0);
    acc("R5 asid wrong", 1, 1, 0, 1, 32'h0012_3456, 8'h81, 32'h0);
    acc("R6 write on read cond", 1, 1, 1, 1, 32'h0012_3456, 8'h80, 32'h0);
    acc("R6 internal on local cond", 0, 1, 0, 1, 32'h0012_3456, 8'h80, 32'h0);
    acc("R8 A ignores data", 1, 1, 0, 1, 32'h0012_3456, 8'h80, 32'hDEAD_BEEF);
    wreg(10, 32'h1);
    check("R10 flag A cleared", rdata, 32'(m_flag));
    acc("R2 block base", 1, 1, 1, 1, 32'h000A_BC00, 8'h70, 32'h0000_A512);
    acc("R2 block top", 1, 1, 1, 1, 32'h000A_BCFE, 8'h70, 32'h0000_A512);
    acc("R4 misaligned word", 1, 1, 1, 1, 32'h000A_BCFF, 8'h70, 32'h0000_A512);
    acc("R2 outside block", 1, 1, 1, 1, 32'h000A_BD00, 8'h70, 32'h0000_A512);
    acc("R4 byte on word cond", 1, 1, 1, 0, 32'h000A_BC12, 8'h70, 32'h0000_0012);
    acc("R7 word upper lane", 1, 1, 1, 1, 32'h000A_BC02, 8'h70, 32'hA512_0000);
    acc("R7 data mismatch", 1, 1, 1, 1, 32'h000A_BC00, 8'h70, 32'h0000_A513);

    // internal-bus fetch / byte write scenario
    wreg(0, 32'h0031_4156); wreg(3, cw(1, 0, 2'd0, 2'd1, 2'd1, 2'd1));
    wreg(4, 32'h0005_5555); wreg(5, 0);
    wreg(7, cw(1, 1, 2'd1, 2'd2, 2'd2, 2'd1));
    wreg(8, 32'h78); wreg(9, 32'h0F);
    acc("R6 fetch hit", 0, 0, 0, 1, 32'h0031_4156, 8'h80, 32'h0);
    acc("R6 data read on fetch cond", 0, 1, 0, 1, 32'h0031_4156, 8'h80, 32'h0);
    acc("R7 byte lane1 7X", 0, 1, 1, 0, 32'h0005_5555, 8'h70, 32'h0000_7300);
    acc("R7 byte wrong lane", 0, 1, 1, 0, 32'h0005_5555, 8'h70, 32'h0000_0073);
    acc("R7 byte 6X miss", 0, 1, 1, 0, 32'h0005_5555, 8'h70, 32'h0000_6300);
    wreg(3, cw(1, 0, 2'd0, 2'd3, 2'd0, 2'd0));
    acc("R6 never field", 0, 0, 0, 1, 32'h0031_4156, 8'h80, 32'h0);
    wreg(3, cw(0, 0, 2'd0, 2'd0, 2'd0, 2'd0));
    acc("R1 enable clear", 0, 0, 0, 1, 32'h0031_4156, 8'h80, 32'h0);
    // valid low: no pulse
    @(negedge clk);
    bus = 0; kind = 1; wr = 1; sz = 0; addr = 32'h0005_5555; asid = 8'h70; data = 32'h7000;
    @(negedge clk);
    check("R9 no valid no pulse", 32'({brk_a, brk_b}), 32'd0);

    // constrained random
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, d;
      logic [1:0] s;
      logic [7:0] id;
      int ch;
      if (i % 40 == 0) begin
        for (int c = 0; c < 2; c++) begin
          wreg(4'(4*c), $urandom);
          case ($urandom % 4)
            0: wreg(4'(4*c+1), 0);
            1: wreg(4'(4*c+1), 32'hFF);
            2: wreg(4'(4*c+1), 32'hF);
            default: wreg(4'(4*c+1), $urandom & 32'h0000_0F0F);
          endcase
          wreg(4'(4*c+2), $urandom & 32'hFF);
          wreg(4'(4*c+3), cw(($urandom % 8) != 0, $urandom % 2, rf(), rf(), rf(), rf()));
        end
        wreg(8, $urandom);
        wreg(9, ($urandom % 2) ? 32'h0 : ($urandom & 32'h0F0F_0F0F));
        wreg(10, 32'h3);
      end
      ch = $urandom % 2;
      s  = 2'($urandom % 4);
      a  = m_t[ch] ^ ($urandom & 32'h7);
      if ($urandom % 4 != 0) a = a & ~((s == 0) ? 32'h0 : (s == 1) ? 32'h1 : 32'h3);
      id = ($urandom % 5 != 0) ? m_s[ch] : 8'($urandom);
      d  = ($urandom % 2) ? (m_dv << (8 * a[1:0])) : $urandom;
      acc("R2 R3 R4 R5 R6 R7 random", 1'($urandom), 1'($urandom), 1'($urandom), s, a, id, d);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", chk, bad);
    $finish;
  end
endmodule